// File: doc/BRIEF.md
# Cascaded Priority Flag Link

This block is the cascade logic that sits beside one search device so that several devices can be chained, highest priority first, into one deeper system. Three flags pass down the chain: match, multiple match and full. Each device takes these flags from the device above it, combines them with its own results, and hands the combined flags to the device below. The last device in the chain therefore presents the system-wide answer. The top device has its upstream inputs tied off: match and multiple match low, full high.

The device's own results come from its entry array as two vectors: which entries hit on the last compare, and which entries hold valid data. These are reduced locally to match, multiple-match and full. Each result is captured only at the rising edge of the cycle strobe, and only for the cycle kind that produces it: compare cycles load match and multiple match, and write cycles load full. After capture, the chain settles combinationally. Control-register cycles and idle cycles can therefore run while the flags propagate. A device is granted the shared data and address buses only when it holds a match and no device above it does, so at most one device in the system drives them.

There is no streaming data path. All pins are plain level control and status signals, and none of them has back-pressure.

Top module: `flag_cascade_node`

## Requirements
- R1: While `rst_n` is low, the captured match, multiple-match and full flags are cleared. As a result `dn_match` equals `up_match`, `dn_multi` equals `up_multi`, and `dn_full`, `bus_grant` and `bus_oe` are 0.
- R2: When `cyc_stb` rises (it was 0 on the previous clock and is 1 now) with `cyc_kind` = 2'b01 (compare), the next clock edge loads local match (any bit of `hit_vec` set) and local multiple match (two or more bits set). At no other time do these captured values change.
- R3: When `cyc_stb` rises with `cyc_kind` = 2'b10 (write), the next clock edge loads local full (every bit of `valid_vec` set). At no other time does the captured full value change.
- R4: `dn_match` is high when `up_match` is high or when the captured local match is high.
- R5: `bus_grant` is high only when the captured local match is high and `up_match` is low. Across a chain, exactly one device is granted whenever any device matched, and none is granted otherwise.
- R6: `dn_multi` is high in any of three cases: `up_multi` is high, the captured local multiple match is high, or the captured local match and `up_match` are both high.
- R7: `dn_full` is high only when `up_full` is high and the captured local full is high. The last device in the chain therefore reports that every device is full.
- R8: `bus_oe` is high exactly when `bus_grant` and `oe_req` are both high.
- R9: A strobe that stays high on later clocks does not capture again. A strobe rise with `cyc_kind` = 2'b00 (idle) or 2'b11 (control write) changes none of the captured flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_stb | input | 1 | Cycle strobe; its rising edge commits results |
| cyc_kind | input | 2 | Cycle type: 00 idle, 01 compare, 10 write, 11 control write |
| hit_vec | input | ENTRIES | Per-entry hit results of the current compare |
| valid_vec | input | ENTRIES | Per-entry occupied bits |
| up_match | input | 1 | Match from the higher-priority neighbour |
| up_multi | input | 1 | Multiple match from the higher-priority neighbour |
| up_full | input | 1 | Full from the higher-priority neighbour |
| oe_req | input | 1 | Request to drive the shared buses |
| dn_match | output | 1 | Match passed to the lower-priority neighbour |
| dn_multi | output | 1 | Multiple match passed down |
| dn_full | output | 1 | Full passed down |
| bus_grant | output | 1 | This device holds the highest-priority match |
| bus_oe | output | 1 | Enable for this device's data and address bus drivers |

## Verification
Two functions can land in the same cycle. One is a new compare committed on a strobe rise, which changes the grant. The other is a bus-enable request, which must follow the grant. The bench holds `oe_req` high on some devices across the strobe. The enables sampled just after the capture edge must then follow the new ownership, and a stale grant must not carry over. It also produces, within one capture, a match in two devices and a single hit in each. The bench then confirms that multiple match comes from the chain rather than from either device alone, and that only the upper device is enabled.

// File: rtl/flag_cascade_pkg.sv
package flag_cascade_pkg;
  typedef enum logic [1:0] {
    K_IDLE    = 2'b00,
    K_COMPARE = 2'b01,
    K_WRITE   = 2'b10,
    K_CTRL    = 2'b11
  } cyc_kind_e;
endpackage

// File: rtl/hit_summary.sv
module hit_summary #(
  parameter int ENTRIES = 8
) (
  input  logic [ENTRIES-1:0] hit_vec,
  input  logic [ENTRIES-1:0] valid_vec,
  output logic               any_hit,
  output logic               multi_hit,
  output logic               all_full
);
  localparam int STAGES = ENTRIES + 1;

  logic [STAGES-1:0] seen;
  logic [STAGES-1:0] dup;
  logic [STAGES-1:0] occ;

  assign seen[0] = 1'b0;
  assign dup[0]  = 1'b0;
  assign occ[0]  = 1'b1;

  // Ripple prefix: a second hit shows up as a hit seen after an earlier one.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_scan
    assign seen[i+1] = seen[i] | hit_vec[i];
    assign dup[i+1]  = dup[i] | (seen[i] & hit_vec[i]);
    assign occ[i+1]  = occ[i] & valid_vec[i];
  end

  assign any_hit   = seen[ENTRIES];
  assign multi_hit = dup[ENTRIES];
  assign all_full  = occ[ENTRIES];
endmodule

// File: rtl/flag_capture.sv
module flag_capture
  import flag_cascade_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cyc_stb,
  input  cyc_kind_e kind,
  input  logic      any_hit,
  input  logic      multi_hit,
  input  logic      all_full,
  output logic      held_match,
  output logic      held_multi,
  output logic      held_full
);
  logic stb_q;
  logic stb_rise;
  logic load_cmp;
  logic load_wr;

  assign stb_rise = cyc_stb & ~stb_q;
  assign load_cmp = stb_rise & (kind == K_COMPARE);
  assign load_wr  = stb_rise & (kind == K_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q      <= 1'b0;
      held_match <= 1'b0;
      held_multi <= 1'b0;
      held_full  <= 1'b0;
    end else begin
      stb_q <= cyc_stb;
      if (load_cmp) begin
        held_match <= any_hit;
        held_multi <= multi_hit;
      end
      if (load_wr) begin
        held_full <= all_full;
      end
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (!held_match && !held_multi && !held_full));

  p_match_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && !stb_q && kind == K_COMPARE) |=>
      (held_match == $past(any_hit) && held_multi == $past(multi_hit)));

  p_match_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cyc_stb && !stb_q && kind == K_COMPARE) |=>
      ($stable(held_match) && $stable(held_multi)));

  p_full_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && !stb_q && kind == K_WRITE) |=> held_full == $past(all_full));

  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cyc_stb && !stb_q && kind == K_WRITE) |=> $stable(held_full));

  p_level_no_recapture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && stb_q) |=>
      ($stable(held_match) && $stable(held_multi) && $stable(held_full)));

  p_multi_implies_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    held_multi |-> held_match);
endmodule

// File: rtl/chain_link.sv
module chain_link (
  input  logic up_match,
  input  logic up_multi,
  input  logic up_full,
  input  logic held_match,
  input  logic held_multi,
  input  logic held_full,
  input  logic oe_req,
  output logic dn_match,
  output logic dn_multi,
  output logic dn_full,
  output logic bus_grant,
  output logic bus_oe
);
  // Purely combinational so the chain ripples without clock latency.
  assign dn_match  = up_match | held_match;
  assign dn_multi  = up_multi | held_multi | (held_match & up_match);
  assign dn_full   = up_full & held_full;
  assign bus_grant = held_match & ~up_match;
  assign bus_oe    = bus_grant & oe_req;
endmodule

// File: rtl/flag_cascade_node.sv
module flag_cascade_node
  import flag_cascade_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cyc_stb,
  input  logic [1:0]         cyc_kind,
  input  logic [ENTRIES-1:0] hit_vec,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               up_match,
  input  logic               up_multi,
  input  logic               up_full,
  input  logic               oe_req,
  output logic               dn_match,
  output logic               dn_multi,
  output logic               dn_full,
  output logic               bus_grant,
  output logic               bus_oe
);
  cyc_kind_e kind;
  logic any_hit, multi_hit, all_full;
  logic held_match, held_multi, held_full;

  assign kind = cyc_kind_e'(cyc_kind);

  hit_summary #(.ENTRIES(ENTRIES)) u_summary (
    .hit_vec   (hit_vec),
    .valid_vec (valid_vec),
    .any_hit   (any_hit),
    .multi_hit (multi_hit),
    .all_full  (all_full)
  );

  flag_capture u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_stb    (cyc_stb),
    .kind       (kind),
    .any_hit    (any_hit),
    .multi_hit  (multi_hit),
    .all_full   (all_full),
    .held_match (held_match),
    .held_multi (held_multi),
    .held_full  (held_full)
  );

  chain_link u_link (
    .up_match   (up_match),
    .up_multi   (up_multi),
    .up_full    (up_full),
    .held_match (held_match),
    .held_multi (held_multi),
    .held_full  (held_full),
    .oe_req     (oe_req),
    .dn_match   (dn_match),
    .dn_multi   (dn_multi),
    .dn_full    (dn_full),
    .bus_grant  (bus_grant),
    .bus_oe     (bus_oe)
  );

  p_grant_passes_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant |-> (dn_match && !up_match));

  p_upstream_match_forwarded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    up_match |-> dn_match);

  p_full_needs_upstream_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dn_full |-> up_full);

  p_oe_needs_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (bus_grant && oe_req));
endmodule

// File: tb/tb_flag_cascade_node.sv
module tb_flag_cascade_node;
  localparam int N = 4;
  localparam int E = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_stb = 1'b0;
  logic [1:0] cyc_kind = 2'b00;
  logic [N-1:0][E-1:0] hits = '0;
  logic [N-1:0][E-1:0] vals = '0;
  logic [N-1:0] oe_req = '0;

  logic [N:0] cm, cmm, cf;
  logic [N-1:0] grant, oe;

  always #5 clk = ~clk;

  assign cm[0]  = 1'b0;
  assign cmm[0] = 1'b0;
  assign cf[0]  = 1'b1;

  for (genvar i = 0; i < N; i++) begin : g_dev
    flag_cascade_node #(.ENTRIES(E)) dut (
      .clk (clk), .rst_n (rst_n), .cyc_stb (cyc_stb), .cyc_kind (cyc_kind),
      .hit_vec (hits[i]), .valid_vec (vals[i]),
      .up_match (cm[i]), .up_multi (cmm[i]), .up_full (cf[i]),
      .oe_req (oe_req[i]),
      .dn_match (cm[i+1]), .dn_multi (cmm[i+1]), .dn_full (cf[i+1]),
      .bus_grant (grant[i]), .bus_oe (oe[i])
    );
  end

  typedef struct {
    logic sm, smm, sf;
    logic [N-1:0] gr, en;
    string tag;
  } exp_t;

  exp_t q[$];
  int vectors = 0;
  int fails = 0;

  logic mh[N], mmh[N], fh[N];
  logic prev_stb = 1'b0;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic drive(input logic stb, input logic [1:0] k,
                       input logic [N-1:0][E-1:0] h, input logic [N-1:0][E-1:0] v,
                       input logic [N-1:0] o, input string tag);
    exp_t e;
    logic m, mm, f;
    @(negedge clk);
    cyc_stb = stb; cyc_kind = k; hits = h; vals = v; oe_req = o;
    if (stb && !prev_stb) begin
      for (int d = 0; d < N; d++) begin
        if (k == 2'b01) begin
          mh[d]  = (h[d] != '0);
          mmh[d] = ($countones(h[d]) >= 2);
        end
        if (k == 2'b10) fh[d] = (v[d] == '1);
      end
    end
    prev_stb = stb;
    m = 1'b0; mm = 1'b0; f = 1'b1;
    for (int d = 0; d < N; d++) begin
      e.gr[d] = mh[d] & ~m;
      e.en[d] = e.gr[d] & o[d];
      mm = mm | mmh[d] | (mh[d] & m);
      m  = m | mh[d];
      f  = f & fh[d];
    end
    e.sm = m; e.smm = mm; e.sf = f; e.tag = tag;
    q.push_back(e);
  endtask

  // One full strobe pulse: rise, then low.
  task automatic op(input logic [1:0] k, input logic [N-1:0][E-1:0] h,
                    input logic [N-1:0][E-1:0] v, input logic [N-1:0] o, input string tag);
    drive(1'b1, k, h, v, o, tag);
    drive(1'b0, k, h, v, o, tag);
  endtask

  // Monitor: compare shortly after each capture edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check({7'b0, cm[N]}, {7'b0, e.sm}, {e.tag, " R4 system match"});
        check({7'b0, cmm[N]}, {7'b0, e.smm}, {e.tag, " R6 system multiple match"});
        check({7'b0, cf[N]}, {7'b0, e.sf}, {e.tag, " R7 system full"});
        check({4'b0, grant}, {4'b0, e.gr}, {e.tag, " R5 bus grants"});
        check({4'b0, oe}, {4'b0, e.en}, {e.tag, " R8 bus enables"});
        check(8'($countones(grant)), e.sm ? 8'd1 : 8'd0, {e.tag, " R5 grant count"});
      end
    end
  end

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [N-1:0][E-1:0] h, v, full_all;
    for (int d = 0; d < N; d++) begin mh[d] = 0; mmh[d] = 0; fh[d] = 0; end
    full_all = '1;
    repeat (3) @(negedge clk);
    // R1: reset state of the whole chain
    check({7'b0, cm[N]}, 8'd0, "R1 match in reset");
    check({7'b0, cmm[N]}, 8'd0, "R1 multi in reset");
    check({7'b0, cf[N]}, 8'd0, "R1 full in reset");
    check({4'b0, grant}, 8'd0, "R1 grants in reset");
    check({4'b0, oe}, 8'd0, "R1 enables in reset");
    rst_n = 1'b1;

    // R2: compare; dev1 single hit, dev3 two hits; enable requested everywhere
    h = '0; h[1] = 8'h10; h[3] = 8'h06;
    op(2'b01, h, '0, 4'hF, "R2 compare");
    // R6: single hits on dev0 and dev2 give a chain-level multiple match
    h = '0; h[0] = 8'h01; h[2] = 8'h80;
    op(2'b01, h, '0, 4'b0101, "R6 cross-device");
    // R9: strobe held high, hit pattern changes, no new capture
    h = '0; h[3] = 8'h01;
    drive(1'b1, 2'b01, h, '0, 4'hF, "R9 rise");
    h = '0; h[1] = 8'hFF;
    drive(1'b1, 2'b01, h, '0, 4'hF, "R9 level held");
    drive(1'b0, 2'b01, h, '0, 4'hF, "R9 low");
    // R9: control write and idle rises leave flags alone
    op(2'b11, '0, full_all, 4'hF, "R9 control write");
    op(2'b00, '0, full_all, 4'hF, "R9 idle");
    // R3: write with every device full, then one entry vacant
    op(2'b10, h, full_all, 4'h0, "R3 write all full");
    v = full_all; v[2] = 8'hEF;
    op(2'b10, h, v, 4'h0, "R3 write one vacant");
    // R2: compare leaves full alone; no hits anywhere clears match
    op(2'b01, '0, full_all, 4'hF, "R2 compare no hit");
    op(2'b10, full_all, full_all, 4'hF, "R7 write full again");
    // Randomized cycles
    for (int i = 0; i < 60; i++) begin
      for (int d = 0; d < N; d++) begin
        h[d] = 8'($urandom & $urandom & $urandom);
        v[d] = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom | $urandom);
      end
      op(2'($urandom), h, v, 4'($urandom), "R2 R3 random");
    end
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule